// File: doc/BRIEF.md
# Double-Data-Rate Multi-Channel ADC Sample Capture

This block receives the parallel output of a multi-channel analog-to-digital converter whose channels all convert at the same moment, nominally 5 MHz per channel. The converter forwards its own clock together with its data lines, already turned into single-ended signals. Each channel carries half of a sample per clock edge. The block registers the lines on both edges of that forwarded clock, joins the two halves of every channel into a full sample word, and packs one sample from each channel into a single wide beat.

Each beat crosses from the converter clock into the system clock through a small dual-clock FIFO. The FIFO uses Gray-coded pointers and two-flop synchronizers. The beat then leaves on an AXI4-Stream master with a registered output. An enable input, synchronized into the converter domain, gates capture. It only ever admits whole samples.

If the stream consumer stalls long enough for the FIFO to fill, new beats are discarded. A sticky overflow flag in the system domain records the loss until the next reset.

Top module: `adc_ddr_capture`

## Requirements
- R1: While `sys_rst` is high, and on the first system clock edge after it falls, `m_axis_tvalid` and `overflow` are 0.
- R2: Channel c drives lines `adc_lines[7c +: 7]`. Line i carries sample bit 2i+1 at the rising edge of `adc_clk` and sample bit 2i at the following falling edge. Those two halves form one 14-bit sample.
- R3: In `m_axis_tdata`, channel c occupies bits `[16c +: 14]`, so channel 0 is in the least significant lane. Bits `[16c+14 +: 2]` are always 0.
- R4: The level of `capture_en` seen at rising edge k of `adc_clk` decides whether the sample whose rising half arrives at edge k+2 is captured. A sample is either delivered whole or not at all.
- R5: While the FIFO does not fill, every captured sample set is delivered exactly once, in capture order.
- R6: Once `m_axis_tvalid` is high with `m_axis_tready` low, `m_axis_tvalid` stays high and `m_axis_tdata` stays unchanged on the next cycle.
- R7: With the consumer stalled, the block holds 17 beats: 16 in the FIFO and 1 in the output register. Later beats are dropped, and `overflow` rises and stays at 1 until reset.
- R8: After the stalled beats are drained, newly captured samples are delivered again in order.
- R9: While `capture_en` is low, no beat appears on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the stream side |
| sys_rst | input | 1 | Synchronous active-high reset, system domain; also resets the converter side |
| capture_en | input | 1 | Capture gate, asynchronous to `adc_clk` |
| adc_clk | input | 1 | Clock forwarded by the converter |
| adc_lines | input | 28 | Half-sample data lines, 7 per channel |
| m_axis_tdata | output | 64 | Four 16-bit lanes, one zero-padded sample each |
| m_axis_tvalid | output | 1 | Stream beat valid |
| m_axis_tready | input | 1 | Stream consumer ready |
| overflow | output | 1 | Sticky flag: a beat was dropped because the FIFO was full |

## Verification
The assertions assume three things about the inputs. The data lines settle well before each edge of `adc_clk`. `capture_en` changes only between rising edges. `sys_rst` is held long enough for a few converter clock cycles to pass, so that the synchronized reset reaches the converter side.

The stimulus keeps within these limits. It changes the lines in the middle of each clock phase. It toggles enable only at the start of a converter cycle. It holds reset across several converter periods. It also keeps every converter clock edge off the system clock edges, so that no check depends on how simultaneous events are ordered.

// File: rtl/adc_ddr_capture_pkg.sv
package adc_ddr_capture_pkg;
  // Default geometry shared by the capture path
  localparam int DEF_CHANNELS = 4;
  localparam int DEF_SAMPLE_W = 14;
  localparam int DEF_LANE_W   = 16;
  localparam int DEF_FIFO_AW  = 4;
  localparam int DEF_SYNC_STG = 2;
endpackage

// File: rtl/cdc_sync_stages.sv
module cdc_sync_stages #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES] = '{default: INIT};

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/adc_ddr_edge_capture.sv
module adc_ddr_edge_capture #(
  parameter int CHANNELS = 4,
  parameter int SAMPLE_W = 14,
  parameter int LANE_W = 16,
  parameter int SYNC_STG = 2
) (
  input  logic                                   adc_clk,
  input  logic                                   adc_rst,
  input  logic                                   en_async,
  input  logic [CHANNELS*(SAMPLE_W/2)-1:0]       adc_lines,
  output logic                                   beat_valid,
  output logic [CHANNELS*LANE_W-1:0]             beat_data
);
  localparam int HALF = SAMPLE_W / 2;
  localparam int LINE_W = CHANNELS * HALF;
  localparam int BEAT_W = CHANNELS * LANE_W;

  logic              en_s;
  logic [LINE_W-1:0] rise_q;
  logic [LINE_W-1:0] fall_q;
  logic              armed;
  logic [BEAT_W-1:0] merged;

  cdc_sync_stages #(.WIDTH(1), .STAGES(SYNC_STG), .INIT(1'b0)) u_en_sync (
    .clk(adc_clk), .d(en_async), .q(en_s)
  );

  // Rising half (odd bits) and falling half (even bits)
  always_ff @(posedge adc_clk) rise_q <= adc_lines;
  always_ff @(negedge adc_clk) fall_q <= adc_lines;

  // armed marks that rise_q was taken under enable; the matching fall half
  // is always taken before the next rising edge, so no sample is split
  always_ff @(posedge adc_clk) begin
    if (adc_rst) begin
      armed <= 1'b0;
      beat_valid <= 1'b0;
    end else begin
      armed <= en_s;
      beat_valid <= armed;
    end
  end

  always_ff @(posedge adc_clk) begin
    if (armed) beat_data <= merged;
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    for (genvar b = 0; b < HALF; b++) begin : g_bit
      assign merged[c*LANE_W + 2*b + 1] = rise_q[c*HALF + b];
      assign merged[c*LANE_W + 2*b]     = fall_q[c*HALF + b];
    end
    if (LANE_W > SAMPLE_W) begin : g_pad
      assign merged[c*LANE_W + SAMPLE_W +: LANE_W - SAMPLE_W] = '0;
    end
  end

  // R4: a beat only leaves when enable was seen two edges before its capture
  p_enable_gate_r4: assert property (@(posedge adc_clk) disable iff (adc_rst)
    beat_valid |-> $past(en_s, 2));
endmodule

// File: rtl/adc_cdc_fifo.sv
module adc_cdc_fifo #(
  parameter int WIDTH = 64,
  parameter int ADDR_W = 4,
  parameter int SYNC_STG = 2
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic             full,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rdata,
  output logic             empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wbin, wgray, rbin, rgray;
  logic [PTR_W-1:0] wq2, rq2;
  logic [PTR_W-1:0] wbin_n, rbin_n;

  assign wbin_n = wbin + 1'b1;
  assign rbin_n = rbin + 1'b1;

  cdc_sync_stages #(.WIDTH(PTR_W), .STAGES(SYNC_STG), .INIT('0)) u_r2w (
    .clk(wclk), .d(rgray), .q(rq2)
  );
  cdc_sync_stages #(.WIDTH(PTR_W), .STAGES(SYNC_STG), .INIT('0)) u_w2r (
    .clk(rclk), .d(wgray), .q(wq2)
  );

  assign full  = (wgray == {~rq2[PTR_W-1:PTR_W-2], rq2[PTR_W-3:0]});
  assign empty = (rgray == wq2);

  always_ff @(posedge wclk) begin
    if (wr_en && !full) mem[wbin[ADDR_W-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin <= '0;
      wgray <= '0;
    end else if (wr_en && !full) begin
      wbin <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin <= '0;
      rgray <= '0;
    end else if (rd_en && !empty) begin
      rbin <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
    end
  end

  assign rdata = mem[rbin[ADDR_W-1:0]];

  // R5: the synchronized write pointer moves at most one bit per read clock
  p_gray_cross_r5: assert property (@(posedge rclk) disable iff (rrst)
    $onehot0(wq2 ^ $past(wq2)));
  // R5: the reader only pops a non-empty FIFO
  p_pop_nonempty_r5: assert property (@(posedge rclk) disable iff (rrst)
    rd_en |-> !empty);
  // R7: a write offered while full leaves the write pointer alone
  p_drop_when_full_r7: assert property (@(posedge wclk) disable iff (wrst)
    (wr_en && full) |=> $stable(wgray));
endmodule

// File: rtl/adc_ddr_capture.sv
module adc_ddr_capture
  import adc_ddr_capture_pkg::*;
#(
  parameter int CHANNELS = DEF_CHANNELS,
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int LANE_W = DEF_LANE_W,
  parameter int FIFO_AW = DEF_FIFO_AW,
  parameter int SYNC_STG = DEF_SYNC_STG
) (
  input  logic                                sys_clk,
  input  logic                                sys_rst,
  input  logic                                capture_en,
  input  logic                                adc_clk,
  input  logic [CHANNELS*(SAMPLE_W/2)-1:0]    adc_lines,
  output logic [CHANNELS*LANE_W-1:0]          m_axis_tdata,
  output logic                                m_axis_tvalid,
  input  logic                                m_axis_tready,
  output logic                                overflow
);
  localparam int BEAT_W = CHANNELS * LANE_W;

  logic              adc_rst;
  logic              beat_valid;
  logic [BEAT_W-1:0] beat_data;
  logic              fifo_full;
  logic              fifo_empty;
  logic [BEAT_W-1:0] fifo_rdata;
  logic              pop;
  logic              drop_tgl;
  logic              drop_sync;
  logic              drop_prev;

  cdc_sync_stages #(.WIDTH(1), .STAGES(SYNC_STG), .INIT(1'b1)) u_rst_sync (
    .clk(adc_clk), .d(sys_rst), .q(adc_rst)
  );

  adc_ddr_edge_capture #(
    .CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W), .LANE_W(LANE_W), .SYNC_STG(SYNC_STG)
  ) u_cap (
    .adc_clk(adc_clk), .adc_rst(adc_rst), .en_async(capture_en),
    .adc_lines(adc_lines), .beat_valid(beat_valid), .beat_data(beat_data)
  );

  adc_cdc_fifo #(.WIDTH(BEAT_W), .ADDR_W(FIFO_AW), .SYNC_STG(SYNC_STG)) u_fifo (
    .wclk(adc_clk), .wrst(adc_rst), .wr_en(beat_valid), .wdata(beat_data),
    .full(fifo_full),
    .rclk(sys_clk), .rrst(sys_rst), .rd_en(pop), .rdata(fifo_rdata),
    .empty(fifo_empty)
  );

  // Drop events cross as a toggle
  always_ff @(posedge adc_clk) begin
    if (adc_rst) drop_tgl <= 1'b0;
    else if (beat_valid && fifo_full) drop_tgl <= ~drop_tgl;
  end

  cdc_sync_stages #(.WIDTH(1), .STAGES(SYNC_STG), .INIT(1'b0)) u_drop_sync (
    .clk(sys_clk), .d(drop_tgl), .q(drop_sync)
  );

  always_ff @(posedge sys_clk) begin
    drop_prev <= drop_sync;
    if (sys_rst) overflow <= 1'b0;
    else if (drop_sync != drop_prev) overflow <= 1'b1;
  end

  // Registered stream output stage
  assign pop = !fifo_empty && (!m_axis_tvalid || m_axis_tready);

  always_ff @(posedge sys_clk) begin
    if (sys_rst) m_axis_tvalid <= 1'b0;
    else if (pop) m_axis_tvalid <= 1'b1;
    else if (m_axis_tready) m_axis_tvalid <= 1'b0;
  end

  always_ff @(posedge sys_clk) begin
    if (pop) m_axis_tdata <= fifo_rdata;
  end

  p_reset_idle_r1: assert property (@(posedge sys_clk)
    sys_rst |=> (!m_axis_tvalid && !overflow));
  p_hold_beat_r6: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (m_axis_tvalid && !m_axis_tready) |=> (m_axis_tvalid && $stable(m_axis_tdata)));
  p_sticky_overflow_r7: assert property (@(posedge sys_clk) disable iff (sys_rst)
    overflow |=> overflow);
endmodule

// File: tb/adc_ddr_capture_test.sv
module adc_ddr_capture_test;
  localparam int CAP = 17;
  localparam int NVEC = 6;
  // {stimulus ch3..ch0 (14 bits each), expected tdata}
  localparam logic [119:0] VEC [NVEC] = '{
    {{14'h0000, 14'h0000, 14'h0000, 14'h0000}, 64'h0000_0000_0000_0000},
    {{14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3FFF}, 64'h3FFF_3FFF_3FFF_3FFF},
    {{14'h2000, 14'h0001, 14'h2AAA, 14'h1555}, 64'h2000_0001_2AAA_1555},
    {{14'h0ABC, 14'h0789, 14'h0456, 14'h0123}, 64'h0ABC_0789_0456_0123},
    {{14'h0000, 14'h3FFF, 14'h0000, 14'h3FFF}, 64'h0000_3FFF_0000_3FFF},
    {{14'h0F0F, 14'h3C3C, 14'h1357, 14'h2468}, 64'h0F0F_3C3C_1357_2468}
  };

  logic        sys_clk = 1'b0;
  logic        sys_rst = 1'b1;
  logic        capture_en = 1'b0;
  logic        adc_clk = 1'b0;
  logic [27:0] adc_lines = '0;
  logic        m_axis_tready = 1'b1;
  logic [63:0] m_axis_tdata;
  logic        m_axis_tvalid;
  logic        overflow;

  int errors = 0;
  int checks = 0;
  int beats = 0;
  int pushed = 0;
  bit done = 0;
  logic en_d1 = 1'b0, en_d2 = 1'b0, exp_ovf = 1'b0;
  logic [63:0] expq [$];

  adc_ddr_capture uut (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .capture_en(capture_en),
    .adc_clk(adc_clk), .adc_lines(adc_lines), .m_axis_tdata(m_axis_tdata),
    .m_axis_tvalid(m_axis_tvalid), .m_axis_tready(m_axis_tready),
    .overflow(overflow)
  );

  always #4 sys_clk = ~sys_clk;

  function automatic logic [63:0] pad_beat(input logic [55:0] s);
    logic [63:0] r;
    for (int c = 0; c < 4; c++) r[16*c +: 16] = {2'b00, s[14*c +: 14]};
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One converter period; the bench enable model mirrors R4
  task automatic adc_cycle(input logic [55:0] s, input logic [63:0] exp);
    logic [27:0] odd, even;
    logic cap;
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 7; i++) begin
        odd[7*c+i]  = s[14*c + 2*i + 1];
        even[7*c+i] = s[14*c + 2*i];
      end
    cap = en_d2;
    en_d2 = en_d1;
    en_d1 = capture_en;
    if (cap) begin
      if (!m_axis_tready && expq.size() >= CAP) exp_ovf = 1'b1;
      else begin
        expq.push_back(exp);
        pushed++;
      end
    end
    adc_lines = odd;
    #50 adc_clk = 1'b1;
    #50 adc_lines = even;
    #50 adc_clk = 1'b0;
    #50;
  endtask

  task automatic adc_sample(input logic [55:0] s);
    adc_cycle(s, pad_beat(s));
  endtask

  task automatic sys_wait(input int n);
    repeat (n) @(posedge sys_clk);
    #1;
  endtask

  // Stream monitor (R2, R3, R5): sampled at the falling edge
  always @(negedge sys_clk) begin
    if (!sys_rst && m_axis_tvalid && m_axis_tready) begin
      beats++;
      if (expq.size() == 0)
        check(1'b0, "R5", "unexpected beat", m_axis_tdata, 64'h0);
      else begin
        logic [63:0] e;
        e = expq.pop_front();
        check(m_axis_tdata === e, "R2 R3 R5", "beat content", m_axis_tdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge sys_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int b0;
    #1;
    repeat (6) adc_sample('0);
    sys_wait(1);
    sys_rst = 1'b0;
    @(negedge sys_clk);
    check(m_axis_tvalid == 1'b0, "R1", "tvalid after reset", 64'(m_axis_tvalid), 64'h0);
    check(overflow == 1'b0, "R1", "overflow after reset", 64'(overflow), 64'h0);
    sys_wait(1);
    repeat (4) adc_sample('0);

    // R4: the two periods after enabling are not captured
    capture_en = 1'b1;
    adc_sample({14'h1111, 14'h1111, 14'h1111, 14'h1111});
    adc_sample({14'h2222, 14'h2222, 14'h2222, 14'h2222});
    for (int v = 0; v < NVEC; v++) adc_cycle(VEC[v][119:64], VEC[v][63:0]);
    capture_en = 1'b0;
    // R4: two more samples still captured after disabling
    adc_sample({14'h0001, 14'h0002, 14'h0003, 14'h0004});
    adc_sample({14'h3001, 14'h3002, 14'h3003, 14'h3004});
    repeat (3) adc_sample({14'h1234, 14'h1234, 14'h1234, 14'h1234});
    sys_wait(40);
    check(expq.size() == 0, "R4 R5", "vector beats delivered", 64'(expq.size()), 64'h0);
    check(beats == NVEC + 2, "R4", "beat count around enable", 64'(beats), 64'(NVEC + 2));

    // R9: nothing while disabled
    b0 = beats;
    repeat (5) adc_sample({14'h3AAA, 14'h1555, 14'h0F0F, 14'h2345});
    sys_wait(40);
    check(beats == b0, "R9", "no beats while disabled", 64'(beats), 64'(b0));

    // R6: consumer toggling ready while samples stream in
    capture_en = 1'b1;
    fork
      begin
        for (int k = 0; k < 10; k++)
          adc_sample({14'(k * 3 + 1), 14'(k * 5 + 2), 14'(k * 7 + 3), 14'h3FFF - 14'(k)});
        capture_en = 1'b0;
        repeat (4) adc_sample('0);
      end
      begin
        for (int k = 0; k < 600; k++) begin
          @(posedge sys_clk);
          #1 m_axis_tready = (k % 3) != 0;
        end
      end
    join
    sys_wait(1);
    m_axis_tready = 1'b1;
    sys_wait(40);
    check(expq.size() == 0, "R6 R5", "beats delivered under back-pressure",
          64'(expq.size()), 64'h0);

    // R7: stall consumer and overfill
    sys_wait(1);
    m_axis_tready = 1'b0;
    check(overflow == 1'b0, "R7", "no overflow before stall", 64'(overflow), 64'h0);
    b0 = beats;
    capture_en = 1'b1;
    for (int k = 0; k < 22; k++)
      adc_sample({14'h0100 + 14'(k), 14'h0200 + 14'(k), 14'h0300 + 14'(k), 14'h0400 + 14'(k)});
    capture_en = 1'b0;
    repeat (4) adc_sample('0);
    sys_wait(10);
    @(negedge sys_clk);
    check(overflow == 1'b1, "R7", "overflow set", 64'(overflow), 64'(exp_ovf));
    check(m_axis_tvalid == 1'b1, "R6", "tvalid held while stalled", 64'(m_axis_tvalid), 64'h1);
    check(m_axis_tdata === expq[0], "R6", "tdata held while stalled", m_axis_tdata, expq[0]);
    check(expq.size() == CAP, "R7", "beats retained", 64'(expq.size()), 64'(CAP));
    sys_wait(1);
    m_axis_tready = 1'b1;
    sys_wait(40);
    check(beats - b0 == CAP, "R7", "retained beats drained", 64'(beats - b0), 64'(CAP));
    check(overflow == 1'b1, "R7", "overflow sticky after drain", 64'(overflow), 64'h1);

    // R8: capture resumes after drain
    b0 = beats;
    capture_en = 1'b1;
    for (int k = 0; k < 5; k++)
      adc_sample({14'h2A00 + 14'(k), 14'h1500 + 14'(k), 14'h0A00 + 14'(k), 14'h3500 + 14'(k)});
    capture_en = 1'b0;
    repeat (4) adc_sample('0);
    sys_wait(40);
    check(beats - b0 == 5, "R8", "beats after resume", 64'(beats - b0), 64'h5);
    check(expq.size() == 0 && beats == pushed, "R8 R5", "every captured beat seen",
          64'(beats), 64'(pushed));

    // R1: reset clears sticky flag
    sys_wait(1);
    sys_rst = 1'b1;
    repeat (6) adc_sample('0);
    sys_wait(1);
    sys_rst = 1'b0;
    @(negedge sys_clk);
    check(overflow == 1'b0, "R1", "overflow cleared by reset", 64'(overflow), 64'h0);
    check(m_axis_tvalid == 1'b0, "R1", "tvalid cleared by reset", 64'(m_axis_tvalid), 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule